// File: doc/BRIEF.md
# Vector Load Address Generator

This block turns one vector load command into a stream of memory read requests. A command names a base address, an element size, a stride choice, a segment count, a vector length, an optional indexed mode and an optional predicate mask. The block then walks the active elements in ascending order. For each element it emits one request per segment, and each request carries a byte address, the destination register that receives the data and the element slot number.

Three addressing styles are inferred from the command fields. In unit-stride mode the step is the element size. In constant-stride mode the step is a register value. In indexed mode the element's offset is read through a small read port from a vector of offsets, one offset per element. When predication is on, elements whose mask bit is clear are skipped outright: they issue nothing and cost no cycles. Requests leave through a valid/ready handshake at one per cycle. The memory path itself sits outside the block.

Top module: `vec_load_agen`

## Requirements
- R1: `cmd_ready` is high exactly when no load is in progress; a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and all its fields are captured then, so later changes on the command inputs do not affect that load.
- R2: With `cmd_cstride` = 0 the step is the element size in bytes, 2^`cmd_size` (code 2 = 4 bytes, 3 = 8 bytes, 4 = 16 bytes).
- R3: With `cmd_cstride` = 1 the step is the value on `cmd_stride`.
- R4: With `cmd_indexed` = 0, element i segment j is read from base + i*(seglen+1)*step + j*step, modulo 2^32.
- R5: With `cmd_indexed` = 1, `off_idx` shows the current element number, and element i segment j is read from base + `off_data` + j*step.
- R6: Each issued element yields seglen+1 requests. The segment index j runs 0..seglen innermost and elements go in ascending order. `req_reg` = (rd + j) mod 32 and `req_elem` = i.
- R7: With `cmd_pred_en` = 1, element i (i < vl) is issued only if `cmd_mask` bit i is 1. With `cmd_pred_en` = 0, all elements 0..vl-1 are issued.
- R8: Skipped elements take no cycles. With `req_ready` held high, a load of N requests keeps `cmd_ready` low for exactly N cycles, one request per cycle.
- R9: While `req_valid` is high and `req_ready` is low, the request stays valid with address, register and element unchanged.
- R10: A command with vl = 0, or with predication on and no mask bit set below vl, issues no request, and `cmd_ready` is high again on the next cycle.
- R11: After reset, `req_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | 32 | Base byte address |
| cmd_size | input | 3 | log2 of element size in bytes |
| cmd_cstride | input | 1 | 1 = constant stride, 0 = unit stride |
| cmd_stride | input | 32 | Stride in bytes for constant-stride mode |
| cmd_seglen | input | 3 | Segments per element minus one |
| cmd_vl | input | 5 | Vector length, 0..16 |
| cmd_indexed | input | 1 | Offsets come from the offset vector |
| cmd_pred_en | input | 1 | Predication on for the destination |
| cmd_mask | input | 16 | Predicate bits, bit i for element i |
| cmd_rd | input | 5 | First destination register |
| off_idx | output | 4 | Element number whose offset is wanted |
| off_data | input | 32 | Offset of element `off_idx` |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted this cycle |
| req_addr | output | 32 | Byte address |
| req_reg | output | 5 | Destination register |
| req_elem | output | 4 | Element slot |

## Verification
The stall-hold assertion assumes that `off_data` is a pure function of `off_idx` for the whole of a load, so that an indexed address cannot move while a request waits. The bench meets this by modelling the offset vector as a constant array read combinationally and writing it only between loads. The assertions also assume that a new command is offered only while `cmd_ready` is high. The bench offers commands only from idle, and it drives junk on the command inputs during a load to show that they are ignored.

// File: rtl/vlag_pkg.sv
package vlag_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned REG_W  = 5;
    localparam int unsigned SEG_W  = 3;
    localparam int unsigned SZ_W   = 3;
    localparam int unsigned VL_MAX = 16;
    localparam int unsigned VL_W   = $clog2(VL_MAX + 1);
    localparam int unsigned IDX_W  = $clog2(VL_MAX);

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SZ_W-1:0]   size;
        logic              cstride;
        logic [ADDR_W-1:0] stride;
        logic [SEG_W-1:0]  seglen;
        logic [VL_W-1:0]   vl;
        logic              indexed;
        logic              pred_en;
        logic [VL_MAX-1:0] mask;
        logic [REG_W-1:0]  rd;
    } ld_cmd_t;

    function automatic logic [ADDR_W-1:0] unit_bytes(input logic [SZ_W-1:0] code);
        return ADDR_W'(1) << code;
    endfunction

    function automatic logic [VL_W-1:0] next_slot(input logic [IDX_W-1:0] e);
        return VL_W'(e) + VL_W'(1);
    endfunction

endpackage

// File: rtl/vlag_step.sv
module vlag_step
    import vlag_pkg::*;
(
    input  ld_cmd_t           cmd,
    output logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] span
);
    always_comb begin
        step = cmd.cstride ? cmd.stride : unit_bytes(cmd.size);
        span = step * (ADDR_W'(cmd.seglen) + ADDR_W'(1));
    end
endmodule

// File: rtl/vlag_pick.sv
module vlag_pick #(
    parameter int unsigned N  = 16,
    parameter int unsigned VW = $clog2(N + 1),
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [VW-1:0] vl,
    input  logic          pred_en,
    input  logic [VW-1:0] from,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] elig;

    for (genvar k = 0; k < N; k++) begin : g_elig
        assign elig[k] = (VW'(k) >= from) && (VW'(k) < vl) && (!pred_en || mask[k]);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (elig[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/vlag_addr.sv
module vlag_addr
    import vlag_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic              indexed,
    input  logic [ADDR_W-1:0] off_data,
    input  logic [IDX_W-1:0]  elem,
    input  logic [ADDR_W-1:0] span,
    input  logic [ADDR_W-1:0] seg_off,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] elem_off;

    always_comb begin
        elem_off = indexed ? off_data : ADDR_W'(elem) * span;
        addr     = base + elem_off + seg_off;
    end
endmodule

// File: rtl/vec_load_agen.sv
module vec_load_agen
    import vlag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [SZ_W-1:0]   cmd_size,
    input  logic              cmd_cstride,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [SEG_W-1:0]  cmd_seglen,
    input  logic [VL_W-1:0]   cmd_vl,
    input  logic              cmd_indexed,
    input  logic              cmd_pred_en,
    input  logic [VL_MAX-1:0] cmd_mask,
    input  logic [REG_W-1:0]  cmd_rd,
    output logic [IDX_W-1:0]  off_idx,
    input  logic [ADDR_W-1:0] off_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [REG_W-1:0]  req_reg,
    output logic [IDX_W-1:0]  req_elem
);
    phase_t            phase;
    ld_cmd_t           cmd_in;
    ld_cmd_t           lat;
    logic [IDX_W-1:0]  elem;
    logic [SEG_W-1:0]  seg;
    logic [ADDR_W-1:0] seg_off;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] span;

    logic [VL_MAX-1:0] pk_mask;
    logic [VL_W-1:0]   pk_vl;
    logic              pk_pen;
    logic [VL_W-1:0]   pk_from;
    logic              pk_found;
    logic [IDX_W-1:0]  pk_idx;

    always_comb begin
        cmd_in.base    = cmd_base;
        cmd_in.size    = cmd_size;
        cmd_in.cstride = cmd_cstride;
        cmd_in.stride  = cmd_stride;
        cmd_in.seglen  = cmd_seglen;
        cmd_in.vl      = cmd_vl;
        cmd_in.indexed = cmd_indexed;
        cmd_in.pred_en = cmd_pred_en;
        cmd_in.mask    = cmd_mask;
        cmd_in.rd      = cmd_rd;
    end

    vlag_step u_step (
        .cmd  (lat),
        .step (step),
        .span (span)
    );

    always_comb begin
        if (phase == PH_IDLE) begin
            pk_mask = cmd_in.mask;
            pk_vl   = cmd_in.vl;
            pk_pen  = cmd_in.pred_en;
            pk_from = '0;
        end else begin
            pk_mask = lat.mask;
            pk_vl   = lat.vl;
            pk_pen  = lat.pred_en;
            pk_from = next_slot(elem);
        end
    end

    vlag_pick #(
        .N  (VL_MAX),
        .VW (VL_W),
        .IW (IDX_W)
    ) u_pick (
        .mask    (pk_mask),
        .vl      (pk_vl),
        .pred_en (pk_pen),
        .from    (pk_from),
        .found   (pk_found),
        .idx     (pk_idx)
    );

    vlag_addr u_addr (
        .base     (lat.base),
        .indexed  (lat.indexed),
        .off_data (off_data),
        .elem     (elem),
        .span     (span),
        .seg_off  (seg_off),
        .addr     (req_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            lat     <= '0;
            elem    <= '0;
            seg     <= '0;
            seg_off <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        lat     <= cmd_in;
                        seg     <= '0;
                        seg_off <= '0;
                        elem    <= pk_idx;
                        if (pk_found) begin
                            phase <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    if (req_ready) begin
                        if (seg != lat.seglen) begin
                            seg     <= seg + SEG_W'(1);
                            seg_off <= seg_off + step;
                        end else begin
                            seg     <= '0;
                            seg_off <= '0;
                            elem    <= pk_idx;
                            if (!pk_found) begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign cmd_ready = (phase == PH_IDLE);
    assign req_valid = (phase == PH_RUN);
    assign req_reg   = lat.rd + REG_W'(seg);
    assign req_elem  = elem;
    assign off_idx   = elem;

endmodule

// File: rtl/vlag_checker.sv
module vlag_checker
    import vlag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [REG_W-1:0]  req_reg,
    input logic [IDX_W-1:0]  req_elem,
    input logic [VL_W-1:0]   lat_vl,
    input logic              lat_pred_en,
    input logic [VL_MAX-1:0] lat_mask,
    input logic [REG_W-1:0]  lat_rd,
    input logic [SEG_W-1:0]  lat_seglen
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !cmd_ready); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_reg) && $stable(req_elem))); // R9

    AST_MASK_RESPECT: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (!lat_pred_en || lat_mask[req_elem])); // R7

    AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (VL_W'(req_elem) < lat_vl)); // R7

    AST_SEG_STEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_reg != REG_W'(lat_rd + REG_W'(lat_seglen))))
            |=> (req_valid && (req_elem == $past(req_elem))
                 && (req_reg == REG_W'($past(req_reg) + REG_W'(1))))); // R6

    AST_ELEM_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_valid || (req_elem >= $past(req_elem)))); // R6

endmodule

bind vec_load_agen vlag_checker u_vlag_checker (
    .clk         (clk),
    .rst         (rst),
    .cmd_ready   (cmd_ready),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_reg     (req_reg),
    .req_elem    (req_elem),
    .lat_vl      (lat.vl),
    .lat_pred_en (lat.pred_en),
    .lat_mask    (lat.mask),
    .lat_rd      (lat.rd),
    .lat_seglen  (lat.seglen)
);

// File: tb/test_vec_load_agen.sv
`timescale 1ns/1ps
module test_vec_load_agen;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_base;
    logic [2:0]  cmd_size;
    logic        cmd_cstride;
    logic [31:0] cmd_stride;
    logic [2:0]  cmd_seglen;
    logic [4:0]  cmd_vl;
    logic        cmd_indexed;
    logic        cmd_pred_en;
    logic [15:0] cmd_mask;
    logic [4:0]  cmd_rd;
    logic [3:0]  off_idx;
    logic [31:0] off_data;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [4:0]  req_reg;
    logic [3:0]  req_elem;

    logic [31:0] offv [16];
    logic [31:0] exp_addr [256];
    logic [4:0]  exp_reg  [256];
    logic [3:0]  exp_elem [256];

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    assign off_data = offv[off_idx];

    vec_load_agen i_vec_load_agen (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_size(cmd_size), .cmd_cstride(cmd_cstride),
        .cmd_stride(cmd_stride), .cmd_seglen(cmd_seglen), .cmd_vl(cmd_vl),
        .cmd_indexed(cmd_indexed), .cmd_pred_en(cmd_pred_en), .cmd_mask(cmd_mask),
        .cmd_rd(cmd_rd), .off_idx(off_idx), .off_data(off_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_reg(req_reg), .req_elem(req_elem)
    );

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // One load: builds the expected request list, runs it, compares each request.
    task automatic run_load(input string tag, input logic [31:0] base, input logic [2:0] sz,
                            input logic cs, input logic [31:0] strd, input logic [2:0] sl,
                            input logic [4:0] vl, input logic ix, input logic pe,
                            input logic [15:0] mk, input logic [4:0] rd, input bit stall);
        int n = 0;
        int k = 0;
        int busy = 0;
        bit held = 0;
        logic [31:0] h_addr;
        logic [4:0]  h_reg;
        logic [3:0]  h_elem;
        logic [31:0] stp;
        stp = cs ? strd : (32'd1 << sz);
        for (int i = 0; i < int'(vl) && i < 16; i++) begin
            if (!pe || mk[i]) begin
                for (int j = 0; j <= int'(sl); j++) begin
                    logic [31:0] eo;
                    eo = ix ? offv[i] : 32'(i) * (32'(sl) + 32'd1) * stp;
                    exp_addr[n] = base + eo + 32'(j) * stp;
                    exp_reg[n]  = rd + 5'(j);
                    exp_elem[n] = 4'(i);
                    n++;
                end
            end
        end
        @(negedge clk);
        cmd_base = base; cmd_size = sz; cmd_cstride = cs; cmd_stride = strd;
        cmd_seglen = sl; cmd_vl = vl; cmd_indexed = ix; cmd_pred_en = pe;
        cmd_mask = mk; cmd_rd = rd; cmd_valid = 1'b1; req_ready = 1'b1;
        #1;
        check(cmd_ready === 1'b1, $sformatf("R1 %s idle before command: actual cmd_ready=%b expected 1", tag, cmd_ready));
        @(negedge clk);
        cmd_valid = 1'b0;
        // junk on the command inputs: the captured load must not change (R1)
        cmd_base = 32'hDEAD_BEE0; cmd_stride = 32'h777; cmd_rd = 5'd3;
        cmd_mask = ~mk; cmd_seglen = 3'd5; cmd_cstride = ~cs; cmd_indexed = ~ix;
        forever begin
            req_ready = stall ? ((busy % 3) != 1) : 1'b1;
            #1;
            if (cmd_ready) break;
            if (held) begin
                check(req_valid && req_addr == h_addr && req_reg == h_reg && req_elem == h_elem,
                      $sformatf("R9 %s stall hold: actual v=%b a=%h r=%0d e=%0d expected v=1 a=%h r=%0d e=%0d",
                                tag, req_valid, req_addr, req_reg, req_elem, h_addr, h_reg, h_elem));
                held = 0;
            end
            if (req_valid) begin
                if (req_ready) begin
                    if (k < n) begin
                        check(req_addr == exp_addr[k] && req_reg == exp_reg[k] && req_elem == exp_elem[k],
                              $sformatf("%s req %0d: actual a=%h r=%0d e=%0d expected a=%h r=%0d e=%0d",
                                        tag, k, req_addr, req_reg, req_elem, exp_addr[k], exp_reg[k], exp_elem[k]));
                    end else begin
                        check(1'b0, $sformatf("R7 %s extra request: actual a=%h e=%0d expected none",
                                              tag, req_addr, req_elem));
                    end
                    k++;
                end else begin
                    held = 1; h_addr = req_addr; h_reg = req_reg; h_elem = req_elem;
                end
            end
            busy++;
            if (busy > 2000) begin
                check(1'b0, $sformatf("%s watchdog: actual still busy expected done", tag));
                break;
            end
            @(negedge clk);
        end
        check(k == n, $sformatf("R7 %s request count: actual %0d expected %0d", tag, k, n));
        if (!stall)
            check(busy == n, $sformatf("R8 %s busy cycles: actual %0d expected %0d", tag, busy, n));
        req_ready = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_valid === 1'b0 && cmd_ready === 1'b1,
              $sformatf("R11 reset state: actual valid=%b ready=%b expected 0 1", req_valid, cmd_ready));
    endtask

    task automatic t_unit_stride();
        run_load("R2 R4 word", 32'h0000_1000, 3'd2, 1'b0, 32'h0, 3'd0, 5'd4, 1'b0, 1'b0, 16'h0, 5'd8, 0);
        run_load("R2 R4 double", 32'h0000_2004, 3'd3, 1'b0, 32'h0, 3'd1, 5'd3, 1'b0, 1'b0, 16'h0, 5'd1, 0);
        run_load("R2 R4 quad", 32'hFFFF_FFF0, 3'd4, 1'b0, 32'h0, 3'd0, 5'd2, 1'b0, 1'b0, 16'h0, 5'd0, 0);
    endtask

    task automatic t_const_stride();
        run_load("R3 R6 const", 32'h0001_0000, 3'd2, 1'b1, 32'h40, 3'd2, 5'd5, 1'b0, 1'b0, 16'h0, 5'd30, 0);
    endtask

    task automatic t_indexed();
        for (int i = 0; i < 16; i++) offv[i] = 32'h300 - 32'(i) * 32'h18 + 32'(i * i);
        run_load("R5 indexed", 32'h0008_0000, 3'd2, 1'b0, 32'h0, 3'd1, 5'd16, 1'b1, 1'b0, 16'h0, 5'd4, 0);
    endtask

    task automatic t_pred();
        run_load("R7 R8 masked", 32'h0000_4000, 3'd3, 1'b0, 32'h0, 3'd1, 5'd16, 1'b0, 1'b1,
                 16'b1010_0000_0100_1001, 5'd10, 0);
        run_load("R7 unmasked", 32'h0000_5000, 3'd2, 1'b0, 32'h0, 3'd0, 5'd3, 1'b0, 1'b0, 16'h0, 5'd2, 0);
        run_load("R7 vl cut", 32'h0000_6000, 3'd2, 1'b1, 32'h10, 3'd0, 5'd6, 1'b0, 1'b1, 16'hFFC2, 5'd2, 0);
    endtask

    task automatic t_stall();
        run_load("R9 stall", 32'h0000_7000, 3'd2, 1'b1, 32'd12, 3'd1, 5'd6, 1'b0, 1'b1, 16'h003B, 5'd20, 1);
        run_load("R9 R5 stall idx", 32'h0000_0100, 3'd3, 1'b0, 32'h0, 3'd2, 5'd5, 1'b1, 1'b0, 16'h0, 5'd27, 1);
    endtask

    task automatic t_segments();
        run_load("R6 seg max", 32'h0000_9000, 3'd2, 1'b0, 32'h0, 3'd7, 5'd2, 1'b0, 1'b0, 16'h0, 5'd28, 0);
    endtask

    task automatic t_empty();
        run_load("R10 vl zero", 32'h0000_A000, 3'd2, 1'b0, 32'h0, 3'd1, 5'd0, 1'b0, 1'b0, 16'hFFFF, 5'd1, 0);
        run_load("R10 all masked", 32'h0000_B000, 3'd2, 1'b0, 32'h0, 3'd1, 5'd8, 1'b0, 1'b1, 16'hFF00, 5'd1, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual run unfinished expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) offv[i] = 32'h0;
        rst = 1'b1; cmd_valid = 1'b0; req_ready = 1'b1;
        cmd_base = '0; cmd_size = '0; cmd_cstride = 1'b0; cmd_stride = '0; cmd_seglen = '0;
        cmd_vl = '0; cmd_indexed = 1'b0; cmd_pred_en = 1'b0; cmd_mask = '0; cmd_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unit_stride();
        t_const_stride();
        t_indexed();
        t_pred();
        t_stall();
        t_segments();
        t_empty();
        summary();
        $finish;
    end
endmodule